// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block multiplies pairs of signed operands and adds each product into a running sum. A controller takes a start pulse and an operand count. It then accepts exactly that many operand pairs over a valid/ready stream, skipping any cycle in which valid is low. It raises a one-cycle done flag when the last product has been added.

A build parameter, `PIPE`, decides whether a register sits between the multiplier and the adder. The controller carries per-product valid, first and last tags down the pipe. Because of this, the result is the same in both builds; only the latency of done shifts by one cycle. The accumulator is wide enough that the longest allowed run cannot overflow.

On any cycle without a transfer, both multiplier operand registers are loaded with zero instead of holding their old values. Those operand registers have no reset.

Stream rules:
- An operand pair transfers on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is a registered output. It does not depend on `in_valid`.
- The source may hold `in_valid` low for any number of cycles; stalls only delay the result.
- The result side has no back-pressure. `acc_out` keeps the final sum until the first product of the next run lands.

Top module: `mac_pipe_unit`

## Requirements
- R1: While reset is held, and directly after it, `in_ready` is 0, `done` is 0 and `acc_out` is 0.
- R2: When `done` is high, `acc_out` equals the signed sum, over the run, of `a_in*b_in` for every transferred pair. Operands are two's complement, `OP_W` bits wide.
- R3: With no stalls, a start pulse sampled at edge S is followed by transfers at edges S+1 to S+N. `done` is then high after edge S+N+1 when PIPE=0, and after edge S+N+2 when PIPE=1.
- R4: Cycles with `in_valid` low transfer nothing and leave the sum unchanged. Both multiplier operand registers hold zero after such a cycle. `done` comes 1+PIPE edges after the edge of the last transfer.
- R5: After a start with N>0, `in_ready` is high from the next cycle until exactly N pairs have transferred, and low afterwards.
- R6: `done` is high for one cycle per run. After it, `acc_out` holds the final sum while no new run is active.
- R7: The first product of a run replaces the accumulator contents, so no earlier run's sum leaks into the new result.
- R8: A start pulse with `count` = 0 is ignored: `in_ready` stays 0, `acc_out` is unchanged and no `done` follows.
- R9: A run of `MAX_CNT` products at the most negative operand value gives the exact positive sum, without overflow. The accumulator width is 2*OP_W + clog2(MAX_CNT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; loads `count` and arms the clear |
| count | input | CNT_W | Number of pairs in the run (0 to MAX_CNT) |
| in_valid | input | 1 | Operand pair valid (the MAC enable) |
| in_ready | output | 1 | Block accepts an operand pair |
| a_in | input | OP_W | Signed operand A |
| b_in | input | OP_W | Signed operand B (for example, a coefficient) |
| acc_out | output | ACC_W | Signed accumulated sum |
| done | output | 1 | One-cycle flag: `acc_out` is final |

## Verification
A stale operand register or a missing zero gate would add a spurious term. This shows up as a wrong `acc_out` at the very next `done`. A first tag lost in the pipe would let an earlier sum leak into the next run, again visible at that run's `done`. A tag that is late or early in one build shows as `done` one edge off the expected cycle, so every done is checked against both its expected sum and its expected edge. A counter that stops wrong leaves `in_ready` high or low one cycle too long, and this is visible at the port straight after the last transfer.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Guard bits so MAX_CNT full-scale products cannot overflow the sum
  function automatic int guard_bits(input int max_cnt);
    return (max_cnt < 2) ? 1 : $clog2(max_cnt);
  endfunction
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             take,
  output logic             take_first,
  output logic             take_last
);
  logic [CNT_W-1:0] remaining;
  logic             first_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining  <= '0;
      first_pend <= 1'b0;
    end else if (start && count != '0) begin
      remaining  <= count;
      first_pend <= 1'b1;
    end else if (take) begin
      remaining  <= remaining - 1'b1;
      first_pend <= 1'b0;
    end
  end

  assign in_ready   = (remaining != '0);
  assign take       = in_valid & in_ready;
  assign take_first = take & first_pend;
  assign take_last  = take & (remaining == CNT_W'(1));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !start) |=> remaining == CNT_W'($past(remaining) - 1'b1));

  // R8
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && count == '0 && !in_ready) |=> !in_ready);
endmodule

// File: rtl/mac_operand_stage.sv
module mac_operand_stage #(
  parameter int OP_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic                   take_first,
  input  logic                   take_last,
  input  logic signed [OP_W-1:0] a_in,
  input  logic signed [OP_W-1:0] b_in,
  output logic signed [OP_W-1:0] a_q,
  output logic signed [OP_W-1:0] b_q,
  output logic                   v_q,
  output logic                   first_q,
  output logic                   last_q
);
  // Operand registers: no reset, zero-gated by the enable
  always_ff @(posedge clk) begin
    a_q <= take ? a_in : '0;
    b_q <= take ? b_in : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      v_q     <= take;
      first_q <= take_first;
      last_q  <= take_last;
    end
  end

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> (a_q == '0 && b_q == '0));
endmodule

// File: rtl/mac_product_stage.sv
module mac_product_stage #(
  parameter int OP_W = 16,
  parameter bit PIPE = 1'b1,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [OP_W-1:0]   a_q,
  input  logic signed [OP_W-1:0]   b_q,
  input  logic                     v_q,
  input  logic                     first_q,
  input  logic                     last_q,
  output logic signed [PROD_W-1:0] prod,
  output logic                     p_v,
  output logic                     p_first,
  output logic                     p_last
);
  logic signed [PROD_W-1:0] mult;
  assign mult = a_q * b_q;

  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk) prod <= mult;
      always_ff @(posedge clk) begin
        if (rst) begin
          p_v     <= 1'b0;
          p_first <= 1'b0;
          p_last  <= 1'b0;
        end else begin
          p_v     <= v_q;
          p_first <= first_q;
          p_last  <= last_q;
        end
      end
    end else begin : g_wire
      assign prod    = mult;
      assign p_v     = v_q;
      assign p_first = first_q;
      assign p_last  = last_q;
    end
  endgenerate
endmodule

// File: rtl/mac_accumulator.sv
module mac_accumulator #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [PROD_W-1:0] prod,
  input  logic                     p_v,
  input  logic                     p_first,
  input  logic                     p_last,
  output logic signed [ACC_W-1:0]  acc,
  output logic                     done
);
  logic signed [ACC_W-1:0] prod_x;
  assign prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= p_v & p_last;
      if (p_v && p_first) acc <= prod_x;   // R7: clear merged with first add
      else                acc <= acc + prod_x;
    end
  end

  // R4
  stall_prod_chk: assert property (@(posedge clk) disable iff (rst)
    !p_v |-> prod == '0);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !p_v |=> acc == $past(acc));
endmodule

// File: rtl/mac_pipe_unit.sv
module mac_pipe_unit #(
  parameter int OP_W    = 16,
  parameter int MAX_CNT = 256,
  parameter bit PIPE    = 1'b1,
  localparam int CNT_W  = $clog2(MAX_CNT + 1),
  localparam int PROD_W = 2 * OP_W,
  localparam int ACC_W  = PROD_W + mac_pkg::guard_bits(MAX_CNT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [CNT_W-1:0]        count,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [OP_W-1:0]  a_in,
  input  logic signed [OP_W-1:0]  b_in,
  output logic signed [ACC_W-1:0] acc_out,
  output logic                    done
);
  logic take, take_first, take_last;
  logic signed [OP_W-1:0] a_q, b_q;
  logic v_q, first_q, last_q;
  logic signed [PROD_W-1:0] prod;
  logic p_v, p_first, p_last;

  mac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .count(count),
    .in_valid(in_valid), .in_ready(in_ready), .take(take),
    .take_first(take_first), .take_last(take_last)
  );

  mac_operand_stage #(.OP_W(OP_W)) u_ops (
    .clk(clk), .rst(rst), .take(take), .take_first(take_first),
    .take_last(take_last), .a_in(a_in), .b_in(b_in),
    .a_q(a_q), .b_q(b_q), .v_q(v_q), .first_q(first_q), .last_q(last_q)
  );

  mac_product_stage #(.OP_W(OP_W), .PIPE(PIPE)) u_prod (
    .clk(clk), .rst(rst), .a_q(a_q), .b_q(b_q), .v_q(v_q),
    .first_q(first_q), .last_q(last_q), .prod(prod),
    .p_v(p_v), .p_first(p_first), .p_last(p_last)
  );

  mac_accumulator #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .prod(prod), .p_v(p_v), .p_first(p_first),
    .p_last(p_last), .acc(acc_out), .done(done)
  );
endmodule

// File: tb/test_mac_pipe_unit.sv
module test_mac_pipe_unit;
  localparam int OP_W = 16, MAX_CNT = 256, CNT_W = 9, ACC_W = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic in_valid = 1'b0;
  logic signed [OP_W-1:0] a_in = '0, b_in = '0;
  logic rdy1, rdy0, done1, done0;
  logic signed [ACC_W-1:0] acc1, acc0;

  always #5 clk = ~clk;

  mac_pipe_unit #(.OP_W(OP_W), .MAX_CNT(MAX_CNT), .PIPE(1'b1)) i_mac_pipe_unit (
    .clk(clk), .rst(rst), .start(start), .count(count), .in_valid(in_valid),
    .in_ready(rdy1), .a_in(a_in), .b_in(b_in), .acc_out(acc1), .done(done1));

  mac_pipe_unit #(.OP_W(OP_W), .MAX_CNT(MAX_CNT), .PIPE(1'b0)) i_mac_pipe_unit_flat (
    .clk(clk), .rst(rst), .start(start), .count(count), .in_valid(in_valid),
    .in_ready(rdy0), .a_in(a_in), .b_in(b_in), .acc_out(acc0), .done(done0));

  int total = 0, bad = 0;
  int ecount = 0;
  int ndone1 = 0, ndone0 = 0;
  bit pdone1 = 0, pdone0 = 0;
  longint q_sum1[$], q_sum0[$];
  int q_edge1[$], q_edge0[$];
  longint last_sum = 0;

  always @(posedge clk) ecount <= ecount + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int mode);
    int r;
    if (mode == 2) return -32768;
    r = int'($urandom % 4);
    if (mode == 1 && r == 0) return -32768;
    if (mode == 1 && r == 1) return 32767;
    if (mode == 1 && r == 2) return -1;
    return int'($urandom % 65536) - 32768;
  endfunction

  // Scoreboard monitor (R2, R3, R4, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (done1) begin
        ndone1++;
        chk(!pdone1, "R6 done1 single cycle", 1, 0);
        if (q_sum1.size() == 0) chk(1'b0, "R2 unexpected done1", 1, 0);
        else begin
          longint es; int ee;
          es = q_sum1.pop_front(); ee = q_edge1.pop_front();
          chk(longint'(acc1) == es, "R2 sum pipe", longint'(acc1), es);
          chk(ecount == ee, "R3 done edge pipe", ecount, ee);
        end
      end
      if (done0) begin
        ndone0++;
        chk(!pdone0, "R6 done0 single cycle", 1, 0);
        if (q_sum0.size() == 0) chk(1'b0, "R2 unexpected done0", 1, 0);
        else begin
          longint es; int ee;
          es = q_sum0.pop_front(); ee = q_edge0.pop_front();
          chk(longint'(acc0) == es, "R2 sum flat", longint'(acc0), es);
          chk(ecount == ee, "R3 done edge flat", ecount, ee);
        end
      end
      pdone1 = done1;
      pdone0 = done0;
    end
  end

  // Driver: R3 R4 R5 R7
  task automatic run(input int n, input int stall_pct, input int mode);
    int taken = 0;
    int last = 0;
    longint sum = 0;
    @(negedge clk); start = 1'b1; count = CNT_W'(n); in_valid = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(rdy1 && rdy0, "R5 ready after start", {rdy1, rdy0}, 3);
    while (taken < n) begin
      int a, b;
      bit v;
      v = (int'($urandom % 100) >= stall_pct);
      a = pick(mode); b = pick(mode);
      in_valid = v; a_in = OP_W'(a); b_in = OP_W'(b);
      if (v && rdy1) begin
        sum += longint'(a) * longint'(b);
        taken++;
        last = ecount + 1;
      end
      if (taken < n) @(negedge clk);
    end
    q_sum1.push_back(sum); q_edge1.push_back(last + 2);
    q_sum0.push_back(sum); q_edge0.push_back(last + 1);
    last_sum = sum;
    @(negedge clk); in_valid = 1'b0; a_in = '0; b_in = '0;
    chk(!rdy1 && !rdy0, "R5 ready drops after N", {rdy1, rdy0}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(!rdy1 && !rdy0 && !done1 && !done0, "R1 reset outputs", {rdy1, rdy0, done1, done0}, 0);
    chk(acc1 == 0 && acc0 == 0, "R1 reset acc", longint'(acc1), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rdy1 && !rdy0 && acc1 == 0 && acc0 == 0, "R1 after reset", {rdy1, rdy0}, 0);

    run(1, 0, 0);        // R3 single
    run(5, 0, 0);        // R3 / R7 back-to-back
    run(8, 40, 1);       // R4 stalls, extremes
    run(20, 30, 1);      // R4 R7
    repeat (6) @(negedge clk);
    // R6 hold after done
    chk(longint'(acc1) == last_sum, "R6 hold pipe", longint'(acc1), last_sum);
    chk(longint'(acc0) == last_sum, "R6 hold flat", longint'(acc0), last_sum);

    // R8 zero count ignored
    begin
      int d1, d0;
      d1 = ndone1; d0 = ndone0;
      @(negedge clk); start = 1'b1; count = '0;
      @(negedge clk); start = 1'b0;
      repeat (4) begin
        @(negedge clk);
        chk(!rdy1 && !rdy0, "R8 ready stays low", {rdy1, rdy0}, 0);
      end
      chk(longint'(acc1) == last_sum && longint'(acc0) == last_sum,
          "R8 acc unchanged", longint'(acc1), last_sum);
      chk(ndone1 == d1 && ndone0 == d0, "R8 no done", ndone1 - d1, 0);
    end

    run(MAX_CNT, 0, 2);  // R9 full-length extreme run
    repeat (6) @(negedge clk);
    chk(longint'(acc1) == 64'sd274877906944, "R9 no overflow pipe", longint'(acc1), 64'sd274877906944);
    chk(longint'(acc0) == 64'sd274877906944, "R9 no overflow flat", longint'(acc0), 64'sd274877906944);

    for (int i = 0; i < 10; i++) run(1 + int'($urandom % 40), int'($urandom % 50), int'($urandom % 2));
    repeat (10) @(negedge clk);
    chk(q_sum1.size() == 0 && q_sum0.size() == 0, "R2 all results seen",
        q_sum1.size() + q_sum0.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule